// File: doc/BRIEF.md
# Overflow Flag Exhaustive Self-Check Sequencer

This block runs a built-in self-test of a small add/subtract unit's signed-overflow flag. After a start pulse it feeds the unit every pair of operands, under both carry-in values and both operations. For each case it compares the flag the unit reports with a prediction. The prediction does not use sign bits. It comes from wide unsigned arithmetic on a second copy of the operands that is offset by half the range.

Each operand held in the sequencer is an unsigned count `u`. The value sent to the unit is `u` with its top bit inverted, so the unsigned value 0 is paired with the most negative signed value. The flag and the prediction are added together into a small tally. A tally of 1 is a disagreement. It stops the run and freezes the failing case for inspection. A tally of 0 or 2 counts as agreement.

The error output goes high when a run starts. It returns low only when the whole sweep completes without a disagreement. The unit under test sits inside the block. A parameter can make it corrupt its flag for one chosen case, which shows that a fault is detected.

Top module: `ovf_selfcheck`

## Requirements
- R1: After reset, busy_o, pass_o, fail_o, err_o and all fail_* outputs are 0.
- R2: A start_i pulse while idle makes busy_o and err_o 1 and pass_o and fail_o 0 from the next cycle.
- R3: Cases run in this fixed order: carry-in 1 sweep first, then carry-in 0. Within each sweep the second operand is the middle loop and the first operand is the inner loop, both counting u from 0. Within each case add (fail_sub_o=0) comes before subtract (fail_sub_o=1). The operand presented to the unit is u with bit W-1 inverted.
- R4: For add, overflow is predicted when u1+u2+cin < 2^(W-1) or > 2^W+2^(W-1)-1 (for W=8: below 128 or above 383).
- R5: For subtract, D = 2^W(2^W-1) + u1 - u2 - (1-cin). Overflow is predicted when D < 2^W(2^W-1) - 2^(W-1) or D > 2^W(2^W-1) + 2^(W-1) - 1 (for W=8: below 65152 or above 65407).
- R6: A case fails when the tally of the unit's flag plus the prediction equals exactly 1. The run stops at the first such case.
- R7: Each operation takes two cycles. A clean run keeps busy_o high for exactly 8·2^(2W) cycles and then ends with pass_o=1, err_o=0 and fail_o=0.
- R8: On a failure, fail_o=1 and err_o stays 1. fail_a_o and fail_b_o hold the presented operands, fail_cin_o holds the carry-in and fail_sub_o holds the operation. These values are held until the next start, which clears fail_o.
- R9: A start_i pulse while busy_o is 1 has no effect on the run's length or outcome.
- R10: Each case is issued as a one-cycle valid pulse to the unit, and the unit answers with done one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sweep (ignored while busy) |
| busy_o | output | 1 | Sweep in progress |
| pass_o | output | 1 | Last sweep completed with every case agreeing |
| fail_o | output | 1 | Last sweep stopped on a disagreement |
| err_o | output | 1 | Set at start, cleared only by a clean completion |
| fail_a_o | output | W | First operand of the failing case, as presented |
| fail_b_o | output | W | Second operand of the failing case, as presented |
| fail_cin_o | output | 1 | Carry-in of the failing case |
| fail_sub_o | output | 1 | Operation of the failing case (1 = subtract) |

## Verification
The assertions assume that start_i is a synchronous level sampled at the clock edge. They also assume that the internal unit returns exactly one done per valid, on the following cycle. The bench drives start_i as one-cycle pulses away from the active edge, including one pulse in the middle of a run. It runs clean sweeps at W=4 and W=5 and two single-case fault variants at W=4. The expected run lengths and the frozen failure fields are computed from the loop order and the two-cycle case cost.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;
endpackage

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_pkg::*;
#(
  parameter int W         = 8,
  parameter bit FAULT_EN  = 1'b0,
  parameter int FAULT_A   = 0,
  parameter int FAULT_B   = 0,
  parameter bit FAULT_CIN = 1'b0,
  parameter bit FAULT_SUB = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic         done_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] res;
  logic         ovf_calc;
  logic         ovf_d;
  logic         done_q;
  logic         ovf_q;

  // operand conditioning and signed-overflow from sign bits
  always_comb begin
    b_eff    = (op_i == OP_SUB) ? ~b_i : b_i;
    res      = a_i + b_eff + W'(cin_i);
    ovf_calc = (a_i[W-1] == b_eff[W-1]) && (res[W-1] != a_i[W-1]);
  end

  generate
    if (FAULT_EN) begin : g_fault
      logic hit;
      always_comb begin
        hit   = (a_i == W'(FAULT_A)) && (b_i == W'(FAULT_B)) &&
                (cin_i == FAULT_CIN) && (op_i == alu_op_e'(FAULT_SUB));
        ovf_d = ovf_calc ^ hit;
      end
    end else begin : g_clean
      always_comb ovf_d = ovf_calc;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) ovf_q <= ovf_d;
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  // R10: answer exactly one cycle after a request
  p_done_follows_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);
  p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);
endmodule

// File: rtl/ovf_predict.sv
module ovf_predict
  import ovf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] u1_i,
  input  logic [W-1:0] u2_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output logic         pred_o
);
  localparam int unsigned N    = 1 << W;
  localparam int unsigned H    = 1 << (W - 1);
  localparam int          PW   = 2 * W + 2;
  localparam int unsigned BASE = N * N - N;
  localparam logic [PW-1:0] ADD_LO = PW'(H);
  localparam logic [PW-1:0] ADD_HI = PW'(N + H - 1);
  localparam logic [PW-1:0] SUB_LO = PW'(BASE - H);
  localparam logic [PW-1:0] SUB_HI = PW'(BASE + H - 1);

  logic [PW-1:0] sum_w;
  logic [PW-1:0] dif_w;
  logic          add_pred;
  logic          sub_pred;

  // R4 / R5: range tests on offset unsigned values
  always_comb begin
    sum_w    = PW'(u1_i) + PW'(u2_i) + PW'(cin_i);
    dif_w    = PW'(BASE) + PW'(u1_i) - PW'(u2_i) - PW'(!cin_i);
    add_pred = (sum_w < ADD_LO) || (sum_w > ADD_HI);
    sub_pred = (dif_w < SUB_LO) || (dif_w > SUB_HI);
    pred_o   = (op_i == OP_SUB) ? sub_pred : add_pred;
  end
endmodule

// File: rtl/ovf_seq.sv
module ovf_seq
  import ovf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         done_i,
  input  logic         ovf_i,
  input  logic         pred_i,
  output logic         valid_o,
  output alu_op_e      op_o,
  output logic [W-1:0] u1_o,
  output logic [W-1:0] u2_o,
  output logic         cin_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         busy_o,
  output logic         pass_o,
  output logic         fail_o,
  output logic         err_o,
  output logic [W-1:0] fail_a_o,
  output logic [W-1:0] fail_b_o,
  output logic         fail_cin_o,
  output logic         fail_sub_o
);
  localparam logic [W-1:0] U_MAX = {W{1'b1}};
  localparam logic [W-1:0] BIAS  = W'(1) << (W - 1);

  seq_state_e   state_q, state_d;
  logic [W-1:0] u1_q, u1_d;
  logic [W-1:0] u2_q, u2_d;
  logic         cin_q, cin_d;
  alu_op_e      op_q, op_d;
  logic         pass_q, pass_d;
  logic         fail_q, fail_d;
  logic         err_q, err_d;
  logic         cap_en;
  logic [1:0]   tally;
  logic [W-1:0] fa_q, fb_q;
  logic         fcin_q;
  alu_op_e      fop_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    u1_d    = u1_q;
    u2_d    = u2_q;
    cin_d   = cin_q;
    op_d    = op_q;
    pass_d  = pass_q;
    fail_d  = fail_q;
    err_d   = err_q;
    cap_en  = 1'b0;
    tally   = {1'b0, ovf_i} + {1'b0, pred_i};
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_REQ;
          u1_d    = '0;
          u2_d    = '0;
          cin_d   = 1'b1;
          op_d    = OP_ADD;
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          err_d   = 1'b1;
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (done_i) begin
          if (tally == 2'd1) begin
            fail_d  = 1'b1;
            cap_en  = 1'b1;
            state_d = ST_IDLE;
          end else if (op_q == OP_ADD) begin
            op_d    = OP_SUB;
            state_d = ST_REQ;
          end else begin
            op_d    = OP_ADD;
            u1_d    = u1_q + 1'b1;
            state_d = ST_REQ;
            if (u1_q == U_MAX) begin
              u2_d = u2_q + 1'b1;
              if (u2_q == U_MAX) begin
                cin_d = 1'b0;
                if (!cin_q) begin
                  state_d = ST_IDLE;
                  pass_d  = 1'b1;
                  err_d   = 1'b0;
                end
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      u1_q    <= '0;
      u2_q    <= '0;
      cin_q   <= 1'b0;
      op_q    <= OP_ADD;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      u1_q    <= u1_d;
      u2_q    <= u2_d;
      cin_q   <= cin_d;
      op_q    <= op_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      err_q   <= err_d;
    end
  end

  // failure capture, enabled only on a disagreement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q   <= '0;
      fb_q   <= '0;
      fcin_q <= 1'b0;
      fop_q  <= OP_ADD;
    end else if (cap_en) begin
      fa_q   <= u1_q ^ BIAS;
      fb_q   <= u2_q ^ BIAS;
      fcin_q <= cin_q;
      fop_q  <= op_q;
    end
  end

  assign valid_o    = (state_q == ST_REQ);
  assign op_o       = op_q;
  assign u1_o       = u1_q;
  assign u2_o       = u2_q;
  assign cin_o      = cin_q;
  assign a_o        = u1_q ^ BIAS;
  assign b_o        = u2_q ^ BIAS;
  assign busy_o     = (state_q != ST_IDLE);
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign err_o      = err_q;
  assign fail_a_o   = fa_q;
  assign fail_b_o   = fb_q;
  assign fail_cin_o = fcin_q;
  assign fail_sub_o = (fop_q == OP_SUB);

  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && err_o && !pass_o && !fail_o));
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_mismatch_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && done_i && (ovf_i != pred_i)) |=> (fail_o && !busy_o));
  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
  p_err_clears_on_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> pass_o);
  p_fail_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> (fail_o && err_o && $stable(fail_a_o) && $stable(fail_b_o)
                              && $stable(fail_cin_o) && $stable(fail_sub_o)));
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && start_i) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/ovf_selfcheck.sv
module ovf_selfcheck
  import ovf_pkg::*;
#(
  parameter int W         = 8,
  parameter bit FAULT_EN  = 1'b0,
  parameter int FAULT_A   = 0,
  parameter int FAULT_B   = 0,
  parameter bit FAULT_CIN = 1'b0,
  parameter bit FAULT_SUB = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic         busy_o,
  output logic         pass_o,
  output logic         fail_o,
  output logic         err_o,
  output logic [W-1:0] fail_a_o,
  output logic [W-1:0] fail_b_o,
  output logic         fail_cin_o,
  output logic         fail_sub_o
);
  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic         valid;
  logic         done;
  logic         ovf;
  logic         pred;
  alu_op_e      op;
  logic [W-1:0] u1, u2, a, b;
  logic         cin;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ovf_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .done_i     (done),
    .ovf_i      (ovf),
    .pred_i     (pred),
    .valid_o    (valid),
    .op_o       (op),
    .u1_o       (u1),
    .u2_o       (u2),
    .cin_o      (cin),
    .a_o        (a),
    .b_o        (b),
    .busy_o     (busy_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .err_o      (err_o),
    .fail_a_o   (fail_a_o),
    .fail_b_o   (fail_b_o),
    .fail_cin_o (fail_cin_o),
    .fail_sub_o (fail_sub_o)
  );

  ovf_alu #(
    .W(W), .FAULT_EN(FAULT_EN), .FAULT_A(FAULT_A), .FAULT_B(FAULT_B),
    .FAULT_CIN(FAULT_CIN), .FAULT_SUB(FAULT_SUB)
  ) u_alu (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .valid_i (valid),
    .op_i    (op),
    .a_i     (a),
    .b_i     (b),
    .cin_i   (cin),
    .done_o  (done),
    .ovf_o   (ovf)
  );

  ovf_predict #(.W(W)) u_pred (
    .u1_i   (u1),
    .u2_i   (u2),
    .cin_i  (cin),
    .op_i   (op),
    .pred_o (pred)
  );
endmodule

// File: tb/tb_ovf_selfcheck.sv
module tb_ovf_selfcheck;
  logic clk;
  logic rst_n;
  logic [3:0] st;
  wire  [3:0] bz, ps, fl, er, fc, fs;
  wire  [3:0] fa0, fb0, fa2, fb2, fa3, fb3;
  wire  [4:0] fa1, fb1;
  int checks = 0;
  int errs   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // instance 0: clean W=4
  ovf_selfcheck #(.W(4)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(st[0]), .busy_o(bz[0]), .pass_o(ps[0]),
    .fail_o(fl[0]), .err_o(er[0]), .fail_a_o(fa0), .fail_b_o(fb0),
    .fail_cin_o(fc[0]), .fail_sub_o(fs[0]));
  // instance 1: clean W=5
  ovf_selfcheck #(.W(5)) dut_w5 (
    .clk(clk), .rst_n(rst_n), .start_i(st[1]), .busy_o(bz[1]), .pass_o(ps[1]),
    .fail_o(fl[1]), .err_o(er[1]), .fail_a_o(fa1), .fail_b_o(fb1),
    .fail_cin_o(fc[1]), .fail_sub_o(fs[1]));
  // instance 2: fault on subtract, cin=1, u1=5, u2=3 (presented 13, 11)
  ovf_selfcheck #(.W(4), .FAULT_EN(1'b1), .FAULT_A(13), .FAULT_B(11),
                  .FAULT_CIN(1'b1), .FAULT_SUB(1'b1)) dut_fs (
    .clk(clk), .rst_n(rst_n), .start_i(st[2]), .busy_o(bz[2]), .pass_o(ps[2]),
    .fail_o(fl[2]), .err_o(er[2]), .fail_a_o(fa2), .fail_b_o(fb2),
    .fail_cin_o(fc[2]), .fail_sub_o(fs[2]));
  // instance 3: fault on add, cin=0, u1=15, u2=15 (presented 7, 7)
  ovf_selfcheck #(.W(4), .FAULT_EN(1'b1), .FAULT_A(7), .FAULT_B(7),
                  .FAULT_CIN(1'b0), .FAULT_SUB(1'b0)) dut_fa (
    .clk(clk), .rst_n(rst_n), .start_i(st[3]), .busy_o(bz[3]), .pass_o(ps[3]),
    .fail_o(fl[3]), .err_o(er[3]), .fail_a_o(fa3), .fail_b_o(fb3),
    .fail_cin_o(fc[3]), .fail_sub_o(fs[3]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // position of a case in sweep order (R3): carry pass, u2, u1, op
  function automatic int case_len(input int w, input int cin, input int u1,
                                  input int u2, input int sub);
    int n = 1 << w;
    int idx = ((((cin != 0) ? 0 : 1) * n + u2) * n + u1) * 2 + sub;
    return (idx + 1) * 2;
  endfunction

  task automatic run(input int k, input int exp_len, input bit exp_pass, output int cyc);
    @(negedge clk); st[k] = 1'b1;
    @(negedge clk); st[k] = 1'b0;
    chk({bz[k], er[k], ps[k], fl[k]} == 4'b1100, "R2 start arms run",
        int'({bz[k], er[k], ps[k], fl[k]}), 12);
    cyc = 0;
    while (bz[k]) begin @(negedge clk); cyc++; end
    chk(ps[k] == exp_pass, "R7 pass verdict", int'(ps[k]), int'(exp_pass));
    chk(fl[k] == !exp_pass, "R6 fail verdict", int'(fl[k]), int'(!exp_pass));
    chk(er[k] == !exp_pass, "R8 err after run", int'(er[k]), int'(!exp_pass));
    chk(cyc == exp_len, "R3 R7 busy length", cyc, exp_len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    st = 4'b0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bz == 4'b0 && ps == 4'b0 && fl == 4'b0 && er == 4'b0, "R1 reset outputs",
        int'({bz, ps, fl, er}), 0);
    chk(fa0 == 0 && fb0 == 0 && fc[0] == 0 && fs[0] == 0, "R1 reset fail fields",
        int'({fa0, fb0}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bz == 4'b0 && er == 4'b0, "R1 idle after release", int'({bz, er}), 0);

    // R4 R5 R7: clean sweeps agree everywhere
    run(0, 8 * 16 * 16, 1'b1, cyc);
    run(1, 8 * 32 * 32, 1'b1, cyc);

    // R9: start pulse in mid-run changes nothing
    @(negedge clk); st[0] = 1'b1;
    @(negedge clk); st[0] = 1'b0;
    cyc = 0;
    repeat (100) begin @(negedge clk); cyc++; end
    st[0] = 1'b1;
    @(negedge clk); cyc++;
    st[0] = 1'b0;
    chk(bz[0] && er[0], "R9 still busy after extra start", int'({bz[0], er[0]}), 3);
    while (bz[0]) begin @(negedge clk); cyc++; end
    chk(cyc == 8 * 16 * 16, "R9 run length unchanged", cyc, 8 * 16 * 16);
    chk(ps[0] == 1'b1 && er[0] == 1'b0, "R9 verdict unchanged", int'({ps[0], er[0]}), 2);

    // R6 R8: injected subtract fault
    run(2, case_len(4, 1, 5, 3, 1), 1'b0, cyc);
    chk(fa2 == 4'd13, "R8 fail_a sub", int'(fa2), 13);
    chk(fb2 == 4'd11, "R8 fail_b sub", int'(fb2), 11);
    chk(fc[2] == 1'b1, "R8 fail_cin sub", int'(fc[2]), 1);
    chk(fs[2] == 1'b1, "R8 fail_sub sub", int'(fs[2]), 1);
    repeat (20) @(negedge clk);
    chk(fl[2] && fa2 == 4'd13 && !bz[2], "R8 held while idle", int'({fl[2], fa2}), 29);

    // R8: restart clears fail, then same failure again
    run(2, case_len(4, 1, 5, 3, 1), 1'b0, cyc);

    // R3 R6: injected add fault in the carry-0 pass, last operands
    run(3, case_len(4, 0, 15, 15, 0), 1'b0, cyc);
    chk(fa3 == 4'd7 && fb3 == 4'd7, "R8 fail operands add", int'({fa3, fb3}), 119);
    chk(fc[3] == 1'b0 && fs[3] == 1'b0, "R3 fail cin/op add", int'({fc[3], fs[3]}), 0);

    // R10 is checked indirectly: two cycles per operation in every length above
    summary();
    $finish;
  end
endmodule